// File: doc/BRIEF.md
# Programmable Watchdog Fault Detector

This block supervises a single watchdog line driven by a processor or other periodic agent. Each change of level on that line, rising or falling, proves that the agent is alive and restarts a timeout count. If a whole programmed window goes by with no change of level, the block raises two indications. One is a sticky fault flag. The other is a single reset pulse of programmable width.

An 8-bit configuration byte selects the timeout window and the pulse width. All timing is counted in ticks of a one-microsecond enable input, so a fast clock and a scaled tick give the same behaviour. Software clears the sticky flag with a two-step handshake: it reads one fault-status location and then the other. Each output can be inverted on its own, for example to give an active-low reset pulse. The watchdog line passes through a synchronizer before its edges are detected.

Top module: `wdog_fault_det`

## Requirements
- R1: After reset the configuration holds 0x00 and the watchdog is disabled: no fault and no pulse ever appear. Configuration bits 7..5 have no effect, so 0xE0 also means disabled and 0xE1 acts exactly like 0x01.
- R2: Configuration bits 2..0 select the timeout window. Code 0 means disabled. Codes 1 to 7 select 200, 400, 800, 1600, 3200, 6400 and 12800 ms, where one ms is TICKS_PER_MS ticks.
- R3: A rising edge and a falling edge of the watchdog line both restart the timeout count. While edges arrive closer together than the window, no fault is raised.
- R4: When the window expires, the fault flag sets and stays set until it is cleared as described in R7.
- R5: A timeout starts a high pulse on the reset output. Configuration bits 4..3 select its width: code 0 gives 10 µs, code 1 gives 100 µs, code 2 gives 1000 µs and code 3 gives 10000 µs, where one µs is TICKS_PER_US ticks.
- R6: After a timeout the window count starts again. A further window with no edge issues another pulse, and the flag stays set.
- R7: A read strobe on status location 1, followed later by a read strobe on status location 2, clears the flag.
- R8: A read of status location 2 that has no earlier read of location 1 since the last read of location 2 leaves the flag set. Reading the two locations in the opposite order also leaves the flag set.
- R9: When invFlag is high the fault output is inverted. When invPulse is high the pulse output is inverted, which gives a low-going reset pulse.
- R10: A configuration write that changes bits 2..0 restarts the window count. Writing code 0 stops the count and suppresses new faults, but a flag that is already set stays set.
- R11: Window and pulse timers advance only in cycles where usTick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| usTick | input | 1 | One-microsecond timing enable |
| wdIn | input | 1 | Watchdog line (asynchronous) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgData | input | 8 | Configuration byte: [2:0] window, [4:3] pulse width, [7:5] unused |
| rdStat1 | input | 1 | Read strobe for status location 1 |
| rdStat2 | input | 1 | Read strobe for status location 2 |
| invFlag | input | 1 | Invert the fault output |
| invPulse | input | 1 | Invert the pulse output |
| faultOut | output | 1 | Sticky fault flag, after the optional inversion |
| pulseOut | output | 1 | Reset pulse, after the optional inversion |

## Verification
The assertions assume that rdStat2 is the only way the flag can clear. They also assume that the shortest window is far longer than the few cycles of synchronizer latency, so a detected edge can never be followed by a timeout in the very next cycle. The stimulus changes wdIn and the strobes only on falling clock edges. It keeps edge spacing at 150 ticks, well inside the 200-tick shortest window, and places its timing checks with margins of at least ten cycles around each expected expiry. That keeps the results independent of the exact synchronizer depth.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes and settings passed from the control to the datapath
  typedef struct packed {
    logic       restart;
    logic       enable;
    logic [2:0] perCode;
    logic [1:0] pulCode;
  } wdCtrl_t;

  typedef enum logic { RD_IDLE = 1'b0, RD_ARMED = 1'b1 } rdState_t;
endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned TICKS_PER_US = 1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    usTick,
  input  logic    wdIn,
  input  wdCtrl_t ctrl,
  output logic    wdEdge,
  output logic    timeout,
  output logic    pulseActive
);
  localparam int unsigned BASE_TICKS = 200 * TICKS_PER_MS;
  localparam int unsigned CNT_W      = $clog2(BASE_TICKS * 64 + 1);
  localparam int unsigned PUL_MAX    = 10000 * TICKS_PER_US;
  localparam int unsigned PUL_W      = $clog2(PUL_MAX + 1);

  // Synchronizer, with one extra stage kept for edge detection
  logic [SYNC_STAGES:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], wdIn};
  end
  assign wdEdge = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];

  // Window limit: the base window doubles with each code step
  logic [2:0]       shAmt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] winCnt;
  always_comb begin
    shAmt = ctrl.perCode - 3'd1;
    limit = CNT_W'(BASE_TICKS) << shAmt;
  end

  assign timeout = ctrl.enable && !ctrl.restart && !wdEdge && usTick &&
                   (winCnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          winCnt <= '0;
    else if (!ctrl.enable || ctrl.restart || wdEdge || timeout) winCnt <= '0;
    else if (usTick)                                    winCnt <= winCnt + CNT_W'(1);
  end

  // Pulse width table, derived from the tick scale
  logic [PUL_W-1:0] pulseLen;
  logic [PUL_W-1:0] pulCnt;
  always_comb begin
    unique case (ctrl.pulCode)
      2'd0:    pulseLen = PUL_W'(10 * TICKS_PER_US);
      2'd1:    pulseLen = PUL_W'(100 * TICKS_PER_US);
      2'd2:    pulseLen = PUL_W'(1000 * TICKS_PER_US);
      default: pulseLen = PUL_W'(PUL_MAX);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pulCnt <= '0;
    else if (timeout)                  pulCnt <= pulseLen;
    else if (usTick && pulCnt != '0)   pulCnt <= pulCnt - PUL_W'(1);
  end

  assign pulseActive = (pulCnt != '0);
endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWe,
  input  logic [7:0] cfgData,
  input  logic    rdStat1,
  input  logic    rdStat2,
  input  logic    timeout,
  output wdCtrl_t ctrl,
  output logic    faultLatched
);
  logic [4:0] cfgReg;
  rdState_t   rdState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgData[4:0];
  end

  always_comb begin
    ctrl.restart = cfgWe && (cfgData[2:0] != cfgReg[2:0]);
    ctrl.enable  = (cfgReg[2:0] != 3'd0);
    ctrl.perCode = cfgReg[2:0];
    ctrl.pulCode = cfgReg[4:3];
  end

  // Ordered read handshake: location 1 arms, location 2 consumes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdState <= RD_IDLE;
    else if (rdStat1) rdState <= RD_ARMED;
    else if (rdStat2) rdState <= RD_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  faultLatched <= 1'b0;
    else if (timeout)                           faultLatched <= 1'b1;
    else if (rdStat2 && rdState == RD_ARMED)    faultLatched <= 1'b0;
  end
endmodule

// File: rtl/wdog_fault_det.sv
module wdog_fault_det
  import wdog_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned TICKS_PER_US = 1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       wdIn,
  input  logic       cfgWe,
  input  logic [7:0] cfgData,
  input  logic       rdStat1,
  input  logic       rdStat2,
  input  logic       invFlag,
  input  logic       invPulse,
  output logic       faultOut,
  output logic       pulseOut
);
  wdCtrl_t ctrl;
  logic    timeout;
  logic    wdEdge;
  logic    pulseActive;
  logic    faultLatched;
  logic    wdEnable;

  wdog_control u_control (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .rdStat1(rdStat1), .rdStat2(rdStat2), .timeout(timeout),
    .ctrl(ctrl), .faultLatched(faultLatched)
  );

  wdog_datapath #(
    .TICKS_PER_MS(TICKS_PER_MS), .TICKS_PER_US(TICKS_PER_US),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wdIn(wdIn), .ctrl(ctrl),
    .wdEdge(wdEdge), .timeout(timeout), .pulseActive(pulseActive)
  );

  assign wdEnable = ctrl.enable;
  assign faultOut = faultLatched ^ invFlag;
  assign pulseOut = pulseActive ^ invPulse;
endmodule

// File: rtl/wdog_fault_det_chk.sv
module wdog_fault_det_chk (
  input logic clk,
  input logic rstN,
  input logic timeout,
  input logic wdEdge,
  input logic wdEnable,
  input logic pulseActive,
  input logic faultLatched,
  input logic rdStat2
);
  AST_TIMEOUT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> faultLatched); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !rdStat2) |=> faultLatched); // R4
  AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatched) |-> $past(rdStat2)); // R7
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> pulseActive); // R5
  AST_EDGE_REARM: assert property (@(posedge clk) disable iff (!rstN)
    wdEdge |=> !timeout); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |-> !timeout); // R10
endmodule

bind wdog_fault_det wdog_fault_det_chk u_chk (
  .clk(clk), .rstN(rstN), .timeout(timeout), .wdEdge(wdEdge),
  .wdEnable(wdEnable), .pulseActive(pulseActive),
  .faultLatched(faultLatched), .rdStat2(rdStat2)
);

// File: tb/test_wdog_fault_det.sv
module test_wdog_fault_det;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1;
  logic wdIn = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic rdStat1 = 1'b0;
  logic rdStat2 = 1'b0;
  logic invFlag = 1'b0;
  logic invPulse = 1'b0;
  logic faultOut, pulseOut;
  logic halfRate = 1'b0;
  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  always @(negedge clk) usTick <= halfRate ? ~usTick : 1'b1;

  wdog_fault_det #(.TICKS_PER_MS(1), .TICKS_PER_US(1)) i_wdog_fault_det (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wdIn(wdIn), .cfgWe(cfgWe),
    .cfgData(cfgData), .rdStat1(rdStat1), .rdStat2(rdStat2),
    .invFlag(invFlag), .invPulse(invPulse),
    .faultOut(faultOut), .pulseOut(pulseOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setCfg(input logic [7:0] b);
    @(negedge clk); cfgWe = 1'b1; cfgData = b;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic rd1;
    @(negedge clk); rdStat1 = 1'b1;
    @(negedge clk); rdStat1 = 1'b0;
  endtask

  task automatic rd2;
    @(negedge clk); rdStat2 = 1'b1;
    @(negedge clk); rdStat2 = 1'b0;
  endtask

  task automatic clearFault;
    setCfg(8'h00);
    rd1; rd2; waitCyc(1);
  endtask

  // R1: reset state and unused configuration bits
  task automatic tReset;
    waitCyc(300);
    chk("R1 fault after reset", faultOut, 0);
    chk("R1 pulse after reset", pulseOut, 0);
    setCfg(8'hE0);
    waitCyc(300);
    chk("R1 0xE0 stays disabled", faultOut, 0);
    setCfg(8'hE1);
    waitCyc(190);
    chk("R1 0xE1 before window", faultOut, 0);
    waitCyc(25);
    chk("R1 0xE1 acts as 200", faultOut, 1);
  endtask

  // R2/R4: window length for a given code
  task automatic tWindow(input int code);
    int w = 200 << (code - 1);
    clearFault;
    setCfg(8'(code));
    waitCyc(w - 10);
    chk("R2 no fault before window", faultOut, 0);
    waitCyc(25);
    chk("R2 fault after window", faultOut, 1);
    waitCyc(50);
    chk("R4 flag stays set", faultOut, 1);
  endtask

  // R3: both edge directions rearm
  task automatic tEdges;
    clearFault;
    setCfg(8'h01);
    for (int i = 0; i < 10; i++) begin
      waitCyc(150);
      wdIn = ~wdIn;
    end
    waitCyc(150);
    chk("R3 edges keep watchdog quiet", faultOut, 0);
    waitCyc(80);
    chk("R3 timeout once edges stop", faultOut, 1);
  endtask

  // R10: changing the window restarts; code 0 keeps the flag
  task automatic tPeriodChange;
    clearFault;
    setCfg(8'h01);
    waitCyc(150);
    setCfg(8'h02);
    waitCyc(300);
    chk("R10 change restarts count", faultOut, 0);
    waitCyc(120);
    chk("R10 new window expires", faultOut, 1);
    setCfg(8'h00);
    waitCyc(10);
    chk("R10 disable keeps flag", faultOut, 1);
  endtask

  // R11: timers advance only on tick
  task automatic tTickGate;
    clearFault;
    halfRate = 1'b1;
    setCfg(8'h01);
    waitCyc(380);
    chk("R11 half tick rate doubles window", faultOut, 0);
    waitCyc(45);
    chk("R11 half tick rate expiry", faultOut, 1);
    halfRate = 1'b0;
    waitCyc(40);
  endtask

  // R9: output inversion
  task automatic tInvert;
    int w = 0;
    clearFault;
    invFlag = 1'b1; invPulse = 1'b1;
    waitCyc(1);
    chk("R9 inverted idle flag", faultOut, 1);
    chk("R9 inverted idle pulse", pulseOut, 1);
    setCfg(8'h01);
    for (int i = 0; i < 260 && pulseOut; i++) waitCyc(1);
    while (!pulseOut && w < 50) begin w++; waitCyc(1); end
    chk("R9 low-going pulse width", w, 10);
    chk("R9 inverted fault", faultOut, 0);
    invFlag = 1'b0; invPulse = 1'b0;
  endtask

  // R6, R8, R7: repeat pulse, stray reads, ordered clear
  task automatic tRepeatAndClear;
    int gap = 0;
    clearFault;
    setCfg(8'h01);
    for (int i = 0; i < 260 && !pulseOut; i++) waitCyc(1);
    while (pulseOut) waitCyc(1);
    while (!pulseOut && gap < 400) begin gap++; waitCyc(1); end
    chk("R6 second pulse follows", int'(gap < 200 && gap > 180), 1);
    chk("R6 flag still set", faultOut, 1);
    setCfg(8'h00);
    rd2; waitCyc(1);
    chk("R8 lone read of location 2", faultOut, 1);
    rd1; waitCyc(1);
    chk("R8 reversed order keeps flag", faultOut, 1);
    rd1; waitCyc(3); rd2; waitCyc(1);
    chk("R7 ordered reads clear flag", faultOut, 0);
  endtask

  // R5: pulse width per code
  task automatic tPulse(input int pul, input int per, input int expW);
    int w = 0;
    clearFault;
    setCfg(8'((pul << 3) | per));
    for (int i = 0; i < 13000 && !pulseOut; i++) waitCyc(1);
    while (pulseOut && w < 20000) begin w++; waitCyc(1); end
    chk("R5 pulse width", w, expW);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    report;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    tReset;
    tWindow(1);
    tWindow(2);
    tWindow(3);
    tEdges;
    tPeriodChange;
    tTickGate;
    tInvert;
    tRepeatAndClear;
    tPulse(0, 1, 10);
    tPulse(1, 1, 100);
    tPulse(2, 4, 1000);
    tPulse(3, 7, 10000);
    report;
  end
endmodule